// File: doc/BRIEF.md
# Bit-Serial Adder Processor

This block adds two unsigned operands and a carry-in with a single one-bit full adder. A small controller steps that adder once per clock cycle, from the least significant bit upwards. When a start request is accepted, the operands and the carry-in are copied into internal registers. Each step then shifts one bit of each operand into the adder. The sum bit goes into a result shift register and the carry is stored in a flip-flop for the next step. The first step takes the captured carry-in, and every later step takes the stored carry.

Once the last bit is done, the sum and carry-out are copied to output registers and a done flag is raised for one cycle. The outputs keep their values until the next addition finishes. A start request that arrives while an addition is running is ignored. If start is held high, the block runs only once and then waits for start to go low before it accepts another request. The operand width is a parameter, and its default is 4 bits.

Top module: `serial_adder`

## Requirements
- R1: While rst_n is low, and after it is released, sum and carry_out are 0 and done is 0 until an addition completes.
- R2: Each addition gives {carry_out, sum} = op_a + op_b + carry_in, taken as an unsigned WIDTH+1-bit value. For example, 6 + 14 + 1 with WIDTH=4 gives sum=5 and carry_out=1.
- R3: op_a, op_b and carry_in are sampled only at the clock edge that accepts start. Changes to them after that edge do not alter the result.
- R4: Count the accepting edge as edge 0. Done goes high after edge WIDTH and stays high for exactly one cycle.
- R5: A start request made while an addition is in progress is ignored. No extra addition and no extra done pulse follow it.
- R6: If start is still high in the cycle where done is high, no new addition begins until start has been sampled low. After start is released, a new request is accepted again.
- R7: sum and carry_out change only at the edge that raises done. They hold their values at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| start | input | 1 | Request to begin an addition |
| sum | output | WIDTH | Registered sum |
| carry_out | output | 1 | Registered carry out of the top bit |
| done | output | 1 | One-cycle flag marking a new result |

## Verification
The bound checker checks on every cycle that done lasts one cycle and arrives exactly WIDTH cycles after acceptance. It also checks that the result equals the sum of the operands captured at acceptance, that no new acceptance happens while busy or while start is still held after done, and that the outputs change only together with done. The bench's scenarios are what show the externally visible effects. These are that operands changed after the accepting edge leave the result unchanged, that a start pulse while busy leaves no trace once the addition ends, and that a start held high produces exactly one result and then a fresh addition after release. Every combination of operands and carry-in is swept for the default width.

// File: rtl/serial_adder_pkg.sv
// Package: shared controller state type for the bit-serial adder.
// Assumes: nothing beyond standard SystemVerilog.
package serial_adder_pkg;

    // Controller states; binary encoded in three bits.
    typedef enum logic [2:0] {
        SA_IDLE  = 3'd0,   // waiting for a start request
        SA_FIRST = 3'd1,   // bit 0, uses the captured carry-in
        SA_STEP  = 3'd2,   // bits 1..WIDTH-1, use the stored carry
        SA_DONE  = 3'd3,   // result published, done high
        SA_HOLD  = 3'd4    // start still high after done; wait for release
    } sa_state_e;

endpackage

// File: rtl/sa_shift_reg.sv
// Module: sa_shift_reg
// Parallel-load register that shifts right, taking a serial bit into the MSB.
// Assumes: load has priority over shift; both synchronous to clk.
module sa_shift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    input  logic             sin,
    output logic [WIDTH-1:0] q
);

    // Register update: clear, parallel load, or shift right by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end else if (shift) begin
            q <= {sin, q[WIDTH-1:1]};
        end
    end

endmodule

// File: rtl/sa_full_adder.sv
// Module: sa_full_adder
// Single-bit full adder, purely combinational.
// Assumes: none.
module sa_full_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and carry of three one-bit inputs.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end

endmodule

// File: rtl/sa_ctrl.sv
// Module: sa_ctrl
// Control unit: accepts start, sequences WIDTH bit steps, raises done,
// and blocks retriggering while start stays high.
// Assumes: WIDTH >= 2; start is synchronous to clk.
module sa_ctrl
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic shift,
    output logic first,
    output logic last,
    output logic done
);

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WIDTH - 1);

    sa_state_e     state_q, state_d;
    logic [CW-1:0] bit_q;

    // Next-state and control decode.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        first   = 1'b0;
        last    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            SA_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = SA_FIRST;
                end
            end
            SA_FIRST: begin
                shift   = 1'b1;
                first   = 1'b1;
                state_d = SA_STEP;
            end
            SA_STEP: begin
                shift = 1'b1;
                if (bit_q == LAST_IDX) begin
                    last    = 1'b1;
                    state_d = SA_DONE;
                end
            end
            SA_DONE: begin
                done    = 1'b1;
                state_d = start ? SA_HOLD : SA_IDLE;
            end
            SA_HOLD: begin
                if (!start) begin
                    state_d = SA_IDLE;
                end
            end
            default: state_d = SA_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SA_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit-step counter: restarts on the first step, advances on later ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
        end else if (first) begin
            bit_q <= CW'(1);
        end else if (shift && !last) begin
            bit_q <= bit_q + CW'(1);
        end
    end

endmodule

// File: rtl/serial_adder.sv
// Module: serial_adder (top)
// Bit-serial adder: captures operands on start, adds one bit per cycle
// through a single full adder, publishes sum/carry with a one-cycle done.
// Assumes: synchronous active-low reset; WIDTH >= 2.
module serial_adder #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             start,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             done
);

    logic             load, shift, first, last;
    logic [WIDTH-1:0] a_q, b_q, res_q;
    logic             cin_q, carry_q;
    logic             fa_ci, fa_s, fa_co;
    logic [WIDTH-1:0] sum_q;
    logic             cout_q;

    sa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .shift (shift),
        .first (first),
        .last  (last),
        .done  (done)
    );

    // Operand registers: loaded on acceptance, shifted right each step.
    sa_shift_reg #(.WIDTH(WIDTH)) u_a_reg (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(op_a), .sin(1'b0), .q(a_q)
    );

    sa_shift_reg #(.WIDTH(WIDTH)) u_b_reg (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
        .din(op_b), .sin(1'b0), .q(b_q)
    );

    // Result register: sum bits enter at the MSB and move toward bit 0.
    sa_shift_reg #(.WIDTH(WIDTH)) u_res_reg (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .shift(shift),
        .din('0), .sin(fa_s), .q(res_q)
    );

    // Carry select: captured carry-in on the first step, stored carry later.
    always_comb begin
        fa_ci = first ? cin_q : carry_q;
    end

    sa_full_adder u_fa (
        .a  (a_q[0]),
        .b  (b_q[0]),
        .ci (fa_ci),
        .s  (fa_s),
        .co (fa_co)
    );

    // Captured carry-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cin_q <= 1'b0;
        end else if (load) begin
            cin_q <= carry_in;
        end
    end

    // Running carry between bit steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (shift) begin
            carry_q <= fa_co;
        end
    end

    // Output registers: updated only on the final bit step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            cout_q <= 1'b0;
        end else if (last) begin
            sum_q  <= {fa_s, res_q[WIDTH-1:1]};
            cout_q <= fa_co;
        end
    end

    always_comb begin
        sum       = sum_q;
        carry_out = cout_q;
    end

endmodule

// File: rtl/serial_adder_chk.sv
// Module: serial_adder_chk
// Assertion checker bound to serial_adder. Tracks captured operands and the
// cycle count since acceptance with its own registers.
// Assumes: bound with the load strobe of the controller.
module serial_adder_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic             start,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             done,
    input logic             load
);

    logic [WIDTH:0] exp_q;
    logic           busy_q;
    logic [7:0]     lat_q;

    // Reference capture and latency count since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q  <= '0;
            busy_q <= 1'b0;
            lat_q  <= '0;
        end else if (load) begin
            exp_q  <= (WIDTH+1)'(op_a) + (WIDTH+1)'(op_b) + (WIDTH+1)'(carry_in);
            busy_q <= 1'b1;
            lat_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (sum == '0 && !carry_out && !done)); // R1
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rst_n) done |-> ({carry_out, sum} == exp_q)); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy_q && lat_q == 8'(WIDTH))); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
    AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !done) |-> !load); // R5
    AST_HELD_START: assert property (@(posedge clk) disable iff (!rst_n) (done && start) |=> !load); // R6
    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !$stable({carry_out, sum}) |-> done); // R7

endmodule

bind serial_adder serial_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .start     (start),
    .sum       (sum),
    .carry_out (carry_out),
    .done      (done),
    .load      (load)
);

// File: tb/serial_adder_bench.sv
// Bench: exhaustive sweep of the default 4-bit adder, plus retrigger,
// held-start and input-change scenarios. Drives and samples on negedge.
module serial_adder_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] sum;
    logic         carry_out;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W:0] prev_res = '0;
    bit finished = 1'b0;

    serial_adder #(.WIDTH(W)) u_serial_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .start(start), .sum(sum),
        .carry_out(carry_out), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One addition. scramble: change inputs and pulse start while busy.
    task automatic run_op(input int a, input int b, input int c, input bit scramble);
        int lat;
        int exp;
        exp = a + b + c;
        @(negedge clk);
        op_a = W'(a); op_b = W'(b); carry_in = c[0]; start = 1'b1;
        @(negedge clk);              // accepting edge has passed
        start = 1'b0;
        lat = 1;
        if (scramble) begin
            op_a = ~W'(a); op_b = W'(b + 5); carry_in = ~c[0]; start = 1'b1;
        end
        while (!done && lat < 12) begin
            check("R7", int'({carry_out, sum}), int'(prev_res));
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check("R4", lat, W + 1);
        check(scramble ? "R3" : "R2", int'({carry_out, sum}), exp);
        prev_res = (W+1)'(exp);
        @(negedge clk);
        check("R4", int'(done), 0);
        if (scramble) begin
            for (int i = 0; i < W + 3; i++) begin
                @(negedge clk);
                check("R5", int'(done), 0);
            end
            check("R5", int'({carry_out, sum}), exp);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(sum), 0);
        check("R1", int'(carry_out), 0);
        check("R1", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'({carry_out, sum, done}), 0);

        // Example from the requirement: 6 + 14 + 1 -> sum 5, carry 1.
        run_op(6, 14, 1, 1'b0);
        check("R2", int'(sum), 5);
        check("R2", int'(carry_out), 1);

        // Exhaustive sweep; every third case changes inputs mid-run.
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                for (int c = 0; c < 2; c++) begin
                    run_op(a, b, c, ((a + b + c) % 3) == 0);
                end
            end
        end

        // Held start: exactly one addition, then wait for release.
        @(negedge clk);
        op_a = 4'd9; op_b = 4'd9; carry_in = 1'b1; start = 1'b1;
        begin
            int lat;
            lat = 0;
            while (!done && lat < 12) begin
                @(negedge clk);
                lat++;
            end
            check("R6", int'({carry_out, sum}), 19);
            prev_res = 5'd19;
            for (int i = 0; i < 3 * W; i++) begin
                @(negedge clk);
                check("R6", int'(done), 0);
            end
            check("R6", int'({carry_out, sum}), 19);
        end
        start = 1'b0;
        @(negedge clk);
        run_op(3, 12, 0, 1'b0);
        check("R6", int'({carry_out, sum}), 15);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule